// File: doc/BRIEF.md
# Dual 8-bit Reload Timer with Shared PWM Output

This block holds two identical 8-bit down-counting timers behind a register bus that is four bits wide. Each timer has a reload value, a compare value and a count value, each split into two nibble registers. It also has a run/stop control, a reload strobe that can only be written, and a 4-bit field that selects which prescaler tap enable advances the count. The prescaler taps come in on an input vector. The divider chain that makes them lies outside this block.

A running timer counts down by one on each enabled tap. When a tap arrives at count zero, the timer reloads from its reload register and pulses its underflow output for one cycle. Each timer's output runs in one of two modes:

- **Normal mode:** the output flips on every underflow.
- **PWM mode:** the output is high while the count is at or below the compare value.

A single shared output pin carries one of the two timer outputs, chosen by a channel-select bit. An output-enable bit gates the pin, and the pin is low while the enable is clear.

Each channel's run control is a two-state machine:

- **States:** `ST_HALT` and `ST_RUN`.
- **START transition** (`ST_HALT` to `ST_RUN`): taken when the control register is written with that channel's run bit at 1.
- **STOP transition** (`ST_RUN` to `ST_HALT`): taken when the control register is written with that run bit at 0.
- **Other cycles:** all other cycles hold the state.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, all registers read 0. This covers the run states, modes, clock selects, reload, compare and count values. `shared_out` and both `underflow` bits are 0.
- R2: Register map, with each 8-bit value split so the low nibble is at the even address and the high nibble at the next (odd) address:
  - 4/5: reload of timer 0. 6/7: reload of timer 1.
  - 8/9: compare of timer 0. 10/11: compare of timer 1.
  - Address 1 holds bit0 = PWM mode of timer 0, bit1 = PWM mode of timer 1, bit2 = channel select, bit3 = output enable.
  - All of these read back the value written.
- R3: Address 0 bit0/bit1 set the run state of timer 0/1: 1 runs, 0 stops, and it reads back. A running timer decrements by one on each edge where its selected tap is high. A stopped timer holds its count. Counts read at 12/13 (timer 0) and 14/15 (timer 1).
- R4: Writing address 0 with bit2 (timer 0) or bit3 (timer 1) at 1 loads that count from its reload register at the same edge. This takes priority over counting and works while stopped. Writing 0 there has no effect, and these bits always read 0.
- R5: A tap at count 0 on a running timer reloads the count and sets that timer's `underflow` bit high for exactly the following cycle.
- R6: In normal mode (mode bit 0), a timer's output starts at 0 and inverts on every underflow.
- R7: In PWM mode (mode bit 1), a timer's output is 1 when count <= compare and 0 otherwise.
- R8: `shared_out` follows timer 1 when channel select is 1 and timer 0 when it is 0. It is 0 whenever output enable is 0.
- R9: Clock-select registers are at address 2 (timer 0) and 3 (timer 1). The value picks `tap_en[value]`. A value >= NUM_TAPS gives no count enable.
- R10: Writes to the count addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register address (read and write) |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble for `bus_addr` (combinational) |
| tap_en | input | NUM_TAPS | Prescaler tap enables, one per selectable rate |
| underflow | output | 2 | One-cycle underflow pulse per timer |
| shared_out | output | 1 | Gated, muxed timer output pin |

## Verification
The assertions check the following on every cycle:
- The underflow-reload coupling.
- The load strobe landing the reload value.
- A halted count holding still.
- Single-step decrements.
- The toggle on each underflow.
- The silence of unused clock-select codes.
- The gating of the shared pin.

Only the bench scenarios can show the following:
- The nibble ordering of the register map.
- That strobe bits read as zero.
- That count registers ignore writes.
- How mode, channel select and clock select interact over long random runs.

These scenarios are checked against a reference model computed in the bench.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CNT_W = 8;
    localparam int NIB_W = 4;
    localparam int NCH   = 2;
    localparam int SEL_W = 4;
    localparam int SEL_N = 1 << SEL_W;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,  A_MODE  = 4'd1,  A_CSEL0 = 4'd2,  A_CSEL1 = 4'd3,
        A_RLD0L = 4'd4,  A_RLD0H = 4'd5,  A_RLD1L = 4'd6,  A_RLD1H = 4'd7,
        A_CMP0L = 4'd8,  A_CMP0H = 4'd9,  A_CMP1L = 4'd10, A_CMP1H = 4'd11,
        A_CNT0L = 4'd12, A_CNT0H = 4'd13, A_CNT1L = 4'd14, A_CNT1H = 4'd15
    } reg_addr_t;
endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel
    import dtmr_pkg::*;
#(
    parameter int NUM_TAPS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                tick_o
);
    logic [SEL_N-1:0] padded;

    // Codes beyond the supplied taps are tied off so they never count.
    for (genvar k = 0; k < SEL_N; k++) begin : g_pad
        if (k < NUM_TAPS) begin : g_used
            assign padded[k] = taps_i[k];
        end else begin : g_unused
            assign padded[k] = 1'b0;
        end
    end

    assign tick_o = padded[sel_i];

    assert_unused_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) >= NUM_TAPS) |-> !tick_o);
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_wr_i,
    input  logic             run_val_i,
    input  logic             ld_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] rld_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             pwm_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             uf_o,
    output logic             out_o
);
    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             uf_q, tog_q;

    // Run/stop state machine: START and STOP transitions on control writes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_wr_i && run_val_i)  state_d = ST_RUN;
            ST_RUN:  if (run_wr_i && !run_val_i) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Counter, underflow pulse and toggle, driven by the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uf_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            uf_q <= 1'b0;
            if (ld_i) begin
                cnt_q <= rld_i;
            end else if (state_q == ST_RUN && tick_i) begin
                if (cnt_q == '0) begin
                    cnt_q <= rld_i;
                    uf_q  <= 1'b1;
                    tog_q <= ~tog_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = (state_q == ST_RUN);
    assign uf_o  = uf_q;
    assign out_o = pwm_i ? (cnt_q <= cmp_i) : tog_q;

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ld_i) |=> (cnt_q == $past(cnt_q)));
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && !ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_load_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == $past(rld_i) && !uf_q));
    assert_uf_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |-> (cnt_q == $past(rld_i)));
    assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |-> (tog_q != $past(tog_q)));
endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
    import dtmr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [3:0]                 addr_i,
    input  logic [NIB_W-1:0]           wdata_i,
    output logic [NIB_W-1:0]           rdata_o,
    input  logic [NCH-1:0][CNT_W-1:0]  cnt_i,
    input  logic [NCH-1:0]             run_i,
    output logic [NCH-1:0][CNT_W-1:0]  rld_o,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_o,
    output logic [NCH-1:0][SEL_W-1:0]  sel_o,
    output logic [NCH-1:0]             pwm_o,
    output logic                       chsel_o,
    output logic                       oen_o,
    output logic [NCH-1:0]             ld_o,
    output logic                       run_wr_o,
    output logic [NCH-1:0]             run_val_o
);
    reg_addr_t a;
    assign a = reg_addr_t'(addr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_o   <= '0;
            cmp_o   <= '0;
            sel_o   <= '0;
            pwm_o   <= '0;
            chsel_o <= 1'b0;
            oen_o   <= 1'b0;
        end else if (wr_i) begin
            case (a)
                A_MODE: begin
                    pwm_o   <= wdata_i[1:0];
                    chsel_o <= wdata_i[2];
                    oen_o   <= wdata_i[3];
                end
                A_CSEL0: sel_o[0]        <= wdata_i;
                A_CSEL1: sel_o[1]        <= wdata_i;
                A_RLD0L: rld_o[0][3:0]   <= wdata_i;
                A_RLD0H: rld_o[0][7:4]   <= wdata_i;
                A_RLD1L: rld_o[1][3:0]   <= wdata_i;
                A_RLD1H: rld_o[1][7:4]   <= wdata_i;
                A_CMP0L: cmp_o[0][3:0]   <= wdata_i;
                A_CMP0H: cmp_o[0][7:4]   <= wdata_i;
                A_CMP1L: cmp_o[1][3:0]   <= wdata_i;
                A_CMP1H: cmp_o[1][7:4]   <= wdata_i;
                default: ;
            endcase
        end
    end

    // Control address: run bits go to the channel state machines, strobes are pulses.
    assign run_wr_o  = wr_i && (a == A_CTRL);
    assign run_val_o = wdata_i[1:0];
    for (genvar i = 0; i < NCH; i++) begin : g_ld
        assign ld_o[i] = run_wr_o && wdata_i[2+i];
    end

    always_comb begin
        unique case (a)
            A_CTRL:  rdata_o = {2'b00, run_i};
            A_MODE:  rdata_o = {oen_o, chsel_o, pwm_o};
            A_CSEL0: rdata_o = sel_o[0];
            A_CSEL1: rdata_o = sel_o[1];
            A_RLD0L: rdata_o = rld_o[0][3:0];
            A_RLD0H: rdata_o = rld_o[0][7:4];
            A_RLD1L: rdata_o = rld_o[1][3:0];
            A_RLD1H: rdata_o = rld_o[1][7:4];
            A_CMP0L: rdata_o = cmp_o[0][3:0];
            A_CMP0H: rdata_o = cmp_o[0][7:4];
            A_CMP1L: rdata_o = cmp_o[1][3:0];
            A_CMP1H: rdata_o = cmp_o[1][7:4];
            A_CNT0L: rdata_o = cnt_i[0][3:0];
            A_CNT0H: rdata_o = cnt_i[0][7:4];
            A_CNT1L: rdata_o = cnt_i[1][3:0];
            A_CNT1H: rdata_o = cnt_i[1][7:4];
        endcase
    end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_TAPS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [3:0]          bus_wdata,
    output logic [3:0]          bus_rdata,
    input  logic [NUM_TAPS-1:0] tap_en,
    output logic [1:0]          underflow,
    output logic                shared_out
);
    logic [NCH-1:0][CNT_W-1:0] cnt, rld, cmp;
    logic [NCH-1:0][SEL_W-1:0] sel;
    logic [NCH-1:0]            pwm, ld, run, run_val, tick, uf, tout;
    logic                      chsel, oen, run_wr;

    dtmr_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .cnt_i(cnt), .run_i(run),
        .rld_o(rld), .cmp_o(cmp), .sel_o(sel), .pwm_o(pwm), .chsel_o(chsel),
        .oen_o(oen), .ld_o(ld), .run_wr_o(run_wr), .run_val_o(run_val)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dtmr_tick_sel #(.NUM_TAPS(NUM_TAPS)) u_tick (
            .clk(clk), .rst_n(rst_n), .taps_i(tap_en), .sel_i(sel[i]), .tick_o(tick[i])
        );
        dtmr_channel u_ch (
            .clk(clk), .rst_n(rst_n), .run_wr_i(run_wr), .run_val_i(run_val[i]),
            .ld_i(ld[i]), .tick_i(tick[i]), .rld_i(rld[i]), .cmp_i(cmp[i]),
            .pwm_i(pwm[i]), .cnt_o(cnt[i]), .run_o(run[i]), .uf_o(uf[i]), .out_o(tout[i])
        );
    end

    assign underflow  = uf;
    assign shared_out = oen && (chsel ? tout[1] : tout[0]);

    assert_pin_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oen |-> !shared_out);
endmodule

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 12;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic [NT-1:0] tap_en = '0;
    logic [1:0]    underflow;
    logic          shared_out;

    int errors = 0, checks = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_cnt[2], m_rld[2], m_cmp[2];
    logic [3:0] m_sel[2];
    logic       m_run[2], m_pwm[2], m_tog[2], m_uf[2];
    logic       m_ch, m_oen;

    dual_reload_timer #(.NUM_TAPS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_en(tap_en),
        .underflow(underflow), .shared_out(shared_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [3:0] exp_rd(input int a);
        case (a)
            0: return {2'b00, m_run[1], m_run[0]};
            1: return {m_oen, m_ch, m_pwm[1], m_pwm[0]};
            2: return m_sel[0];
            3: return m_sel[1];
            4: return m_rld[0][3:0];   5: return m_rld[0][7:4];
            6: return m_rld[1][3:0];   7: return m_rld[1][7:4];
            8: return m_cmp[0][3:0];   9: return m_cmp[0][7:4];
            10: return m_cmp[1][3:0];  11: return m_cmp[1][7:4];
            12: return m_cnt[0][3:0];  13: return m_cnt[0][7:4];
            14: return m_cnt[1][3:0];  default: return m_cnt[1][7:4];
        endcase
    endfunction

    function automatic string rd_tag(input int a);
        if (a == 0) return "R4 ctrl readback (R3 run bits)";
        if (a == 2 || a == 3) return "R9 clock select readback";
        if (a >= 12) return "R3 count readback";
        return "R2 register readback";
    endfunction

    function automatic logic tmr_out(input int i);
        return m_pwm[i] ? (m_cnt[i] <= m_cmp[i]) : m_tog[i];
    endfunction

    function automatic logic exp_shared();
        return m_oen && (m_ch ? tmr_out(1) : tmr_out(0));
    endfunction

    function automatic string out_tag();
        int i = m_ch ? 1 : 0;
        if (!m_oen) return "R8 pin gated off";
        return m_pwm[i] ? "R7 PWM output via R8 mux" : "R6 toggle output via R8 mux";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_rld[i] = 0; m_cmp[i] = 0; m_sel[i] = 0;
            m_run[i] = 0; m_pwm[i] = 0; m_tog[i] = 0; m_uf[i] = 0;
        end
        m_ch = 0; m_oen = 0;
    endtask

    task automatic model_edge(input logic w, input int a, input logic [3:0] d, input logic [NT-1:0] t);
        for (int i = 0; i < 2; i++) begin
            logic tk = m_run[i] && (int'(m_sel[i]) < NT) && t[m_sel[i]];
            logic ld = w && a == 0 && d[2+i];
            m_uf[i] = 0;
            if (ld) m_cnt[i] = m_rld[i];
            else if (tk) begin
                if (m_cnt[i] == 0) begin
                    m_cnt[i] = m_rld[i]; m_tog[i] = ~m_tog[i]; m_uf[i] = 1;
                end else m_cnt[i] = m_cnt[i] - 1;
            end
        end
        if (w) case (a)
            0: begin m_run[0] = d[0]; m_run[1] = d[1]; end
            1: begin m_pwm[0] = d[0]; m_pwm[1] = d[1]; m_ch = d[2]; m_oen = d[3]; end
            2: m_sel[0] = d;
            3: m_sel[1] = d;
            4: m_rld[0][3:0] = d;  5: m_rld[0][7:4] = d;
            6: m_rld[1][3:0] = d;  7: m_rld[1][7:4] = d;
            8: m_cmp[0][3:0] = d;  9: m_cmp[0][7:4] = d;
            10: m_cmp[1][3:0] = d; 11: m_cmp[1][7:4] = d;
            default: ;
        endcase
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input logic w, input int a, input logic [3:0] d, input logic [NT-1:0] t);
        bus_wr = w; bus_addr = 4'(a); bus_wdata = d; tap_en = t;
        @(posedge clk);
        model_edge(w, a, d, t);
        @(negedge clk);
        chk("R5 underflow[0]", underflow[0], m_uf[0]);
        chk("R5 underflow[1]", underflow[1], m_uf[1]);
        chk(out_tag(), shared_out, exp_shared());
        chk(rd_tag(a), bus_rdata, exp_rd(a));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports and in every register
        chk("R1 shared_out after reset", shared_out, 0);
        chk("R1 underflow after reset", underflow, 0);
        for (int a = 0; a < 16; a++) begin
            bus_addr = 4'(a); #1;
            chk("R1 register after reset", bus_rdata, 0);
        end
        // R2: nibble order of reload/compare
        cyc(1, 4, 4'h3, '0); cyc(1, 5, 4'h0, '0);
        cyc(1, 8, 4'h1, '0); cyc(1, 9, 4'h0, '0);
        cyc(0, 4, 0, '0); cyc(0, 5, 0, '0);
        // R4: strobe loads while stopped, reads 0
        cyc(1, 0, 4'b0100, '0);
        cyc(0, 0, 0, '0);
        cyc(0, 12, 0, '0);
        // R4: writing 0 to strobe bits leaves the count unchanged
        cyc(1, 0, 4'b0000, '0);
        cyc(0, 12, 0, '0);
        // R3/R5/R6: run timer 0 on tap 0, output on, normal mode
        cyc(1, 1, 4'b1000, '0);
        cyc(1, 0, 4'b0001, '0);
        for (int k = 0; k < 12; k++) cyc(0, 12, 0, 12'h001);
        // R7: PWM mode, compare 1
        cyc(1, 1, 4'b1001, '0);
        for (int k = 0; k < 10; k++) cyc(0, 12, 0, (k % 2) ? 12'h001 : 12'h000);
        // R10: writes to count addresses ignored
        cyc(1, 0, 4'b0000, '0);
        cyc(1, 12, 4'hF, '0); cyc(1, 13, 4'hF, '0);
        bus_wr = 0; bus_addr = 4'd12; #1;
        chk("R10 count low after write", bus_rdata, exp_rd(12));
        bus_addr = 4'd13; #1;
        chk("R10 count high after write", bus_rdata, exp_rd(13));
        // R9: timer 1 with unused code 13 and all taps high never counts
        cyc(1, 6, 4'h5, '0);
        cyc(1, 3, 4'd13, '0);
        cyc(1, 0, 4'b1010, '0);
        for (int k = 0; k < 5; k++) cyc(0, 14, 0, '1);
        bus_addr = 4'd14; #1;
        chk("R9 unused code held count", bus_rdata, 4'h5);
        // R8: route timer 1 to the pin
        cyc(1, 1, 4'b1100, '0);
        cyc(1, 3, 4'd2, '0);
        for (int k = 0; k < 8; k++) cyc(0, 14, 0, 12'h004);
        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic w = ($urandom_range(0, 5) == 0);
            int a = $urandom_range(0, 15);
            logic [3:0] d = 4'($urandom);
            logic [NT-1:0] t = NT'($urandom);
            if (w && a == 0 && $urandom_range(0, 3) != 0) d[1:0] = 2'b11;
            if (w && (a == 5 || a == 7)) d = 4'($urandom_range(0, 1));
            cyc(w, a, d, t);
        end
        summary();
    end
endmodule